// File: doc/BRIEF.md
# Flash Busy Status Output Generator

This block sits on the read path of a parallel flash device model. While an internal program or erase is running, a read must not return array contents; it returns status bits that the host polls to see when the operation has finished. The block takes the busy flag from the operation engine, the kind of operation, the byte being programmed, the array read data and a read strobe. From these it produces the 8-bit value driven onto the data bus.

Two status signals are driven at the same time. Bit 7 is a data-polarity indicator. During a program it returns the inverse of the bit 7 being written. During an erase it returns 0. Bit 6 is a toggle that changes value on each read strobe while the device is busy. The toggle restarts at 0 when each operation begins.

When busy drops, bit 7 takes its final value at once. Bits 6:0 keep a fixed filler pattern for a settling window of `SETTLE_CYC` clock cycles, which is about 1 µs at the model's clock. After that window, reads return array data. The output is combinational from the current inputs and a few state registers, so a read sees its value in the same cycle as its strobe.

Top module: `flash_stat_out`

## Requirements
- R1: After reset, and while the block is idle and outside any settling window, `dq_o` equals `array_data_i` in every cycle.
- R2: While `busy_i` is 1 and `erase_op_i` is 0 (program), `dq_o[7]` equals the inverse of `prog_data_i[7]`.
- R3: While `busy_i` is 1 and `erase_op_i` is 1 (erase), `dq_o[7]` is 0.
- R4: While busy, `dq_o[6]` holds its value in cycles without `rd_stb_i`. After each cycle with `rd_stb_i` = 1, it takes the opposite value.
- R5: While busy, `dq_o[5:0]` equals `FILL_PAT[5:0]` (default `FILL_PAT` = 7'b1010101).
- R6: For exactly `SETTLE_CYC` cycles after `busy_i` falls, starting with the first cycle in which it is low, `dq_o[6:0]` equals `FILL_PAT`. In the same cycles, `dq_o[7]` is 1 after an erase, or the programmed bit 7 (as sampled when the operation started) after a program.
- R7: Once the settling window has elapsed, `dq_o` equals `array_data_i`, and read strobes no longer change bit 6.
- R8: In the first busy cycle of every operation, `dq_o[6]` is 0, whatever value the toggle had at the end of the previous operation.
- R9: If `busy_i` rises again during a settling window, status reporting (R2 to R5, R8) takes effect at once and the window is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy_i | input | 1 | Internal program or erase running |
| erase_op_i | input | 1 | Operation kind: 1 = erase, 0 = program; stable while busy |
| prog_data_i | input | 8 | Byte being programmed; stable while busy |
| array_data_i | input | 8 | Data read from the array |
| rd_stb_i | input | 1 | One-cycle strobe per completed read |
| dq_o | output | 8 | Value driven on the data bus |

## Verification
The bound checker verifies on every cycle the bit-7 polarity for program and erase, and the fixed filler in the low bits while busy. It also checks that bit 6 holds or flips according to the read strobes, and that bit 6 starts at 0 when an operation begins. Using its own cycle counter, it confirms that the filler covers exactly the settling window after busy falls, and that array data passes through once the window ends. Some behaviour only the bench scenarios can show. These are that bit 7 in the window keeps the value latched at operation start, that a restart in the middle of a window abandons it cleanly, and that a toggle left at 1 by an odd read count does not leak into the next operation. Random operation lengths, read densities and idle gaps, both shorter and longer than the window, exercise these paths.

// File: rtl/flash_stat_pkg.sv
// Package: shared types and defaults for the flash busy status output path.
// Assumes: nothing beyond a one-byte data bus.
package flash_stat_pkg;
    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_kind_e;

    localparam int          BUS_W        = 8;
    localparam logic [6:0]  FILL_DEFAULT = 7'b1010101;
endpackage

// File: rtl/fsg_toggle.sv
// Module: fsg_toggle
// Keeps the bit-6 toggle and the operation context captured at start.
// Assumes: start is a single-cycle pulse in the first busy cycle, and the
// operation inputs are valid in that cycle.
module fsg_toggle
    import flash_stat_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic     busy,
    input  logic     rd_stb,
    input  logic     erase_in,
    input  logic     bit7_in,
    output logic     tog,
    output op_kind_e kind,
    output logic     bit7_saved
);
    logic     tog_q;
    op_kind_e kind_q;
    logic     b7_q;

    // Effective values: the start cycle already reports the new operation.
    always_comb begin
        tog        = start ? 1'b0 : tog_q;
        kind       = start ? op_kind_e'(erase_in) : kind_q;
        bit7_saved = b7_q;
    end

    // Toggle state: restart at each operation, flip on each read while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else if (busy && rd_stb) begin
            tog_q <= ~tog;
        end else if (start) begin
            tog_q <= 1'b0;
        end
    end

    // Operation context: capture kind and programmed bit 7 when work begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= OP_PROGRAM;
            b7_q   <= 1'b0;
        end else if (start) begin
            kind_q <= op_kind_e'(erase_in);
            b7_q   <= bit7_in;
        end
    end
endmodule

// File: rtl/fsg_settle.sv
// Module: fsg_settle
// Times the post-completion window during which only bit 7 is valid.
// Assumes: SETTLE_CYC >= 1; done pulses in the first idle cycle after busy.
module fsg_settle #(
    parameter int SETTLE_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic done,
    output logic settling
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] remain_q;

    // The done cycle itself is the first cycle of the window.
    always_comb begin
        settling = done || (remain_q != '0);
    end

    // Remaining window count: load on done, clear on new busy, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (busy) begin
            remain_q <= '0;
        end else if (done) begin
            remain_q <= LOAD_VAL;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end
endmodule

// File: rtl/flash_stat_out.sv
// Module: flash_stat_out (top)
// Chooses the data-bus value: busy status, settling filler, or array data.
// Assumes: erase_op_i and prog_data_i are stable while busy_i is high, and
// rd_stb_i marks one cycle per completed read.
module flash_stat_out
    import flash_stat_pkg::*;
#(
    parameter int         SETTLE_CYC = 100,
    parameter logic [6:0] FILL_PAT   = FILL_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_i,
    input  logic             erase_op_i,
    input  logic [BUS_W-1:0] prog_data_i,
    input  logic [BUS_W-1:0] array_data_i,
    input  logic             rd_stb_i,
    output logic [BUS_W-1:0] dq_o
);
    logic     busy_q;
    logic     op_start;
    logic     op_done;
    logic     tog;
    op_kind_e kind;
    logic     bit7_saved;
    logic     settling;

    // Busy history register for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else begin
            busy_q <= busy_i;
        end
    end

    // Edge decode of the busy flag.
    always_comb begin
        op_start = busy_i && !busy_q;
        op_done  = !busy_i && busy_q;
    end

    fsg_toggle u_tog (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (op_start),
        .busy       (busy_i),
        .rd_stb     (rd_stb_i),
        .erase_in   (erase_op_i),
        .bit7_in    (prog_data_i[BUS_W-1]),
        .tog        (tog),
        .kind       (kind),
        .bit7_saved (bit7_saved)
    );

    fsg_settle #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy_i),
        .done     (op_done),
        .settling (settling)
    );

    // Output select: status while busy, filler while settling, else array.
    always_comb begin
        if (busy_i) begin
            dq_o = {(kind == OP_ERASE) ? 1'b0 : ~prog_data_i[BUS_W-1],
                    tog, FILL_PAT[5:0]};
        end else if (settling) begin
            dq_o = {(kind == OP_ERASE) ? 1'b1 : bit7_saved, FILL_PAT};
        end else begin
            dq_o = array_data_i;
        end
    end
endmodule

// File: rtl/flash_stat_out_chk.sv
// Module: flash_stat_out_chk
// Port-level checker for flash_stat_out, bound into every instance.
// Assumes: the same parameters as the checked instance.
module flash_stat_out_chk #(
    parameter int         SETTLE_CYC = 100,
    parameter logic [6:0] FILL_PAT   = 7'b1010101
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy_i,
    input logic       erase_op_i,
    input logic [7:0] prog_data_i,
    input logic [7:0] array_data_i,
    input logic       rd_stb_i,
    input logic [7:0] dq_o
);
    localparam int IW = $clog2(SETTLE_CYC + 1);
    localparam logic [IW-1:0] SAT = IW'(SETTLE_CYC);

    logic [IW-1:0] idle_c;

    // Idle cycles since busy last was high, saturating at the window length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_c <= SAT;
        end else if (busy_i) begin
            idle_c <= '0;
        end else if (idle_c != SAT) begin
            idle_c <= idle_c + 1'b1;
        end
    end

    a_r2_prog_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !erase_op_i) |-> (dq_o[7] == ~prog_data_i[7]));

    a_r3_erase_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && erase_op_i) |-> (dq_o[7] == 1'b0));

    a_r4_flip_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && $past(busy_i) && $past(rd_stb_i)) |-> (dq_o[6] != $past(dq_o[6])));

    a_r4_hold_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && $past(busy_i) && !$past(rd_stb_i)) |-> $stable(dq_o[6]));

    a_r5_busy_filler: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> (dq_o[5:0] == FILL_PAT[5:0]));

    a_r6_settle_filler: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && idle_c != SAT) |-> (dq_o[6:0] == FILL_PAT));

    a_r7_array_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && idle_c == SAT) |-> (dq_o == array_data_i));

    a_r8_toggle_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_i) |-> (dq_o[6] == 1'b0));
endmodule

bind flash_stat_out flash_stat_out_chk #(
    .SETTLE_CYC (SETTLE_CYC),
    .FILL_PAT   (FILL_PAT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_i       (busy_i),
    .erase_op_i   (erase_op_i),
    .prog_data_i  (prog_data_i),
    .array_data_i (array_data_i),
    .rd_stb_i     (rd_stb_i),
    .dq_o         (dq_o)
);

// File: tb/flash_stat_out_test.sv
// Bench for flash_stat_out: directed corner cases plus seeded random ops.
module flash_stat_out_test;
    localparam int         SET  = 100;
    localparam logic [6:0] FILL = 7'b1010101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busy_i = 1'b0;
    logic       erase_op_i = 1'b0;
    logic [7:0] prog_data_i = 8'h00;
    logic [7:0] array_data_i = 8'h00;
    logic       rd_stb_i = 1'b0;
    logic [7:0] dq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Reference state derived from the requirements.
    logic m_busy_q = 1'b0;
    logic m_tog = 1'b0;
    int   m_idle = SET;
    logic m_erase = 1'b0;
    logic m_b7 = 1'b0;

    always #5 clk = ~clk;

    flash_stat_out #(.SETTLE_CYC(SET), .FILL_PAT(FILL)) uut (
        .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .erase_op_i(erase_op_i),
        .prog_data_i(prog_data_i), .array_data_i(array_data_i),
        .rd_stb_i(rd_stb_i), .dq_o(dq_o)
    );

    // Reference model update at each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy_q <= 1'b0; m_tog <= 1'b0; m_idle <= SET;
            m_erase <= 1'b0; m_b7 <= 1'b0;
        end else begin
            if (busy_i && !m_busy_q) begin
                m_tog <= rd_stb_i;
                m_erase <= erase_op_i;
                m_b7 <= prog_data_i[7];
            end else if (busy_i && rd_stb_i) begin
                m_tog <= ~m_tog;
            end
            m_idle <= busy_i ? 0 : ((m_idle < SET) ? m_idle + 1 : m_idle);
            m_busy_q <= busy_i;
        end
    end

    function automatic logic [7:0] exp_dq();
        logic st;
        st = busy_i && !m_busy_q;
        if (busy_i)
            return {erase_op_i ? 1'b0 : ~prog_data_i[7], st ? 1'b0 : m_tog, FILL[5:0]};
        else if (m_idle < SET)
            return {m_erase ? 1'b1 : m_b7, FILL};
        else
            return array_data_i;
    endfunction

    function automatic string auto_tag();
        if (busy_i) return erase_op_i ? "R3/R4/R5" : "R2/R4/R5";
        if (m_idle < SET) return "R6";
        return "R7";
    endfunction

    // Compare the whole bus mid-cycle, then move to the next falling edge.
    task automatic tick(input string tag);
        logic [7:0] e;
        #2;
        e = exp_dq();
        n_chk++;
        if (dq_o !== e) begin
            n_bad++;
            $display("FAIL %s: dq_o=%h expected %h (t=%0t)", tag, dq_o, e, $time);
        end
        @(negedge clk);
    endtask

    task automatic check_bit(input string tag, input int pos, input logic want);
        n_chk++;
        if (dq_o[pos] !== want) begin
            n_bad++;
            $display("FAIL %s: dq_o[%0d]=%b expected %b", tag, pos, dq_o[pos], want);
        end
    endtask

    task automatic run_op(input logic er, input logic [7:0] pd, input int blen,
                          input int idle_len, input int pct);
        busy_i = 1'b1; erase_op_i = er; prog_data_i = pd;
        for (int i = 0; i < blen; i++) begin
            rd_stb_i = (($urandom % 100) < pct);
            array_data_i = 8'($urandom);
            tick(auto_tag());
        end
        busy_i = 1'b0;
        for (int i = 0; i < idle_len; i++) begin
            rd_stb_i = $urandom % 2;
            array_data_i = 8'($urandom);
            tick(auto_tag());
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset passes array data.
        for (int i = 0; i < 4; i++) begin
            array_data_i = 8'($urandom); rd_stb_i = i[0];
            tick("R1");
        end

        // R4/R8: program 0x80, odd read count leaves toggle at 1.
        busy_i = 1'b1; erase_op_i = 1'b0; prog_data_i = 8'h80; rd_stb_i = 1'b1;
        #2; check_bit("R8", 6, 1'b0); check_bit("R2", 7, 1'b0); #0;
        @(negedge clk);
        rd_stb_i = 1'b0; #2; check_bit("R4", 6, 1'b1); @(negedge clk);
        rd_stb_i = 1'b1; #2; check_bit("R4", 6, 1'b1); @(negedge clk);
        rd_stb_i = 1'b1; #2; check_bit("R4", 6, 1'b0); @(negedge clk);
        rd_stb_i = 1'b0; tick("R4");
        // End program: settle then array (R6/R7).
        busy_i = 1'b0; array_data_i = 8'h3C;
        #2; check_bit("R6", 7, 1'b1); @(negedge clk);
        for (int i = 1; i < SET + 3; i++) begin
            array_data_i = 8'($urandom); tick(i < SET ? "R6" : "R7");
        end

        // R8: new erase op starts with bit 6 at 0 after odd reads before.
        busy_i = 1'b1; erase_op_i = 1'b1; rd_stb_i = 1'b0;
        #2; check_bit("R8", 6, 1'b0); check_bit("R3", 7, 1'b0); @(negedge clk);
        for (int i = 0; i < 5; i++) begin rd_stb_i = 1'b1; tick("R4"); end
        busy_i = 1'b0; rd_stb_i = 1'b0;
        for (int i = 0; i < 10; i++) tick("R6");
        // R9: restart as a program mid-window.
        busy_i = 1'b1; erase_op_i = 1'b0; prog_data_i = 8'h01;
        #2; check_bit("R9", 7, 1'b1); check_bit("R9", 6, 1'b0); @(negedge clk);
        for (int i = 0; i < 3; i++) begin rd_stb_i = 1'b1; tick("R9"); end
        busy_i = 1'b0; rd_stb_i = 1'b0;
        #2; check_bit("R6", 7, 1'b0); @(negedge clk);
        for (int i = 1; i < SET + 2; i++) tick(i < SET ? "R6" : "R7");

        // Random operations, idle gaps shorter and longer than the window.
        for (int k = 0; k < 60; k++) begin
            run_op($urandom % 2, 8'($urandom), 1 + ($urandom % 40),
                   ($urandom % 2) ? ($urandom % SET) : SET + ($urandom % 40),
                   10 + ($urandom % 90));
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule